// File: doc/BRIEF.md
# Class-G Supply Rail Mode Controller

This block decides whether the charge pump that feeds a stereo headphone driver runs on the full supply rail or on half of it. It looks at the signed output sample of each channel whenever a sample strobe arrives. It compares each sample's magnitude against a programmable level threshold. It then drives a single registered mode bit to the pump.

A two-bit mode input selects how the decision is made. Two codes force the rail to full, one forces it to half, and one lets the block switch by itself. In automatic operation the rail goes to full on the clock after either channel is loud. A loud sample restarts a minimum hold period. After that period, the rail may drop back to half only once both channels have stayed quiet for a detection window. A three-bit code picks that window as a power-of-two multiple of a base tick count.

Top module: `classg_rail_ctrl`

## Requirements
- R1: While the synchronous active-low reset is asserted at a clock edge, the rail output is 0 (half rail) after that edge, and all timers are cleared.
- R2: A mode code of 01 or 11 drives the rail output to 1 (full rail) from the clock edge at which it is sampled.
- R3: A mode code of 10 drives the rail output to 0 (half rail) from the clock edge at which it is sampled.
- R4: In mode 00, a strobed sample whose magnitude is at or above the threshold on either channel sets the rail output to 1 at that edge. The threshold is unsigned, and the magnitude of the most negative code is its unsigned absolute value.
- R5: Sample values presented while the strobe is low have no effect on the rail output.
- R6: In mode 00, the rail stays at 1 for at least HOLD_TICKS clock cycles after the last loud strobed sample. Every loud sample restarts both the hold timer and the quiet timer.
- R7: After the hold period, the rail returns to 0 at the edge where the number of quiet cycles since the last loud sample reaches HOLD_TICKS + (BASE_TICKS << code). The code is the 3-bit detection input as sampled at each edge.
- R8: A change from any forced mode to mode 00 sets the rail to 1 on the first automatic edge and starts a fresh hold period, as if a loud sample had arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample strobe; samples are compared only when high |
| smp_left | input | SMP_W | Left channel signed sample |
| smp_right | input | SMP_W | Right channel signed sample |
| level_thr | input | SMP_W | Unsigned switching threshold on sample magnitude |
| rail_mode | input | 2 | 00 automatic, 01 full, 10 half, 11 treated as full |
| quiet_code | input | 3 | Quiet detection window, BASE_TICKS << code cycles |
| rail_full | output | 1 | 1 selects full rail, 0 selects half rail |

## Verification
The bench targets the threshold edge: a magnitude exactly equal to the threshold must count as loud, so an off-by-one comparison would leave the rail at half. It drives the most negative sample code, where a sign-blind or wrapping absolute value would miss a loud sample. It checks that loud values without a strobe are ignored, since a design that compares every cycle would rise early. It measures the exact fall edge after hold plus window for several codes, so a timer that is one cycle short or long, or one not restarted by a loud sample, shows up as a wrong cycle. It also exits forced half mode into automatic mode, where a design without the restart would stay at half.

// File: rtl/classg_rail_ctrl.sv
module classg_rail_ctrl #(
  parameter int SMP_W      = 16,
  parameter int HOLD_TICKS = 4800,
  parameter int BASE_TICKS = 480
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb,
  input  logic signed [SMP_W-1:0] smp_left,
  input  logic signed [SMP_W-1:0] smp_right,
  input  logic        [SMP_W-1:0] level_thr,
  input  logic        [1:0]       rail_mode,
  input  logic        [2:0]       quiet_code,
  output logic                    rail_full
);
  localparam int HW   = $clog2(HOLD_TICKS + 1);
  localparam int QMAX = BASE_TICKS << 7;
  localparam int QW   = $clog2(QMAX + 1);

  function automatic logic [SMP_W-1:0] mag(input logic [SMP_W-1:0] s);
    return s[SMP_W-1] ? (~s + 1'b1) : s;
  endfunction

  logic          rail_q, forced_q;
  logic [HW-1:0] hold_q;
  logic [QW-1:0] quiet_q;
  logic [QW-1:0] quiet_len;
  logic          loud, auto_m;

  assign loud      = smp_stb && ((mag(smp_left) >= level_thr) || (mag(smp_right) >= level_thr));
  assign auto_m    = (rail_mode == 2'b00);
  assign quiet_len = QW'(BASE_TICKS) << quiet_code;
  assign rail_full = rail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rail_q   <= 1'b0;
      forced_q <= 1'b0;
      hold_q   <= '0;
      quiet_q  <= '0;
    end else begin
      forced_q <= !auto_m;
      if (!auto_m) begin
        rail_q  <= (rail_mode != 2'b10);
        hold_q  <= HW'(HOLD_TICKS);
        quiet_q <= '0;
      end else if (forced_q || loud) begin
        rail_q  <= 1'b1;
        hold_q  <= HW'(HOLD_TICKS);
        quiet_q <= '0;
      end else if (rail_q) begin
        if (hold_q != '0) begin
          hold_q <= hold_q - 1'b1;
        end else if ((quiet_q + 1'b1) >= quiet_len) begin
          rail_q  <= 1'b0;
          quiet_q <= '0;
        end else begin
          quiet_q <= quiet_q + 1'b1;
        end
      end
    end
  end
endmodule

module classg_rail_ctrl_chk #(
  parameter int SMP_W      = 16,
  parameter int HOLD_TICKS = 4800,
  parameter int BASE_TICKS = 480
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_stb,
  input logic signed [SMP_W-1:0] smp_left,
  input logic signed [SMP_W-1:0] smp_right,
  input logic        [SMP_W-1:0] level_thr,
  input logic        [1:0]       rail_mode,
  input logic        [2:0]       quiet_code,
  input logic                    rail_full
);
  logic [SMP_W-1:0] ml, mr;
  logic             hot;
  int unsigned      run;

  assign ml  = smp_left[SMP_W-1]  ? (~smp_left + 1'b1)  : smp_left;
  assign mr  = smp_right[SMP_W-1] ? (~smp_right + 1'b1) : smp_right;
  assign hot = smp_stb && (rail_mode == 2'b00) && (ml >= level_thr || mr >= level_thr);

  always_ff @(posedge clk) begin
    if (!rst_n || !rail_full || hot || rail_mode != 2'b00) run <= 0;
    else if (run < 32'hFFFF_0000) run <= run + 1;
  end

  p_reset_half_r1: assert property (@(posedge clk) $past(!rst_n) |-> !rail_full);

  p_forced_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rail_mode[0])) |-> rail_full);

  p_forced_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rail_mode == 2'b10)) |-> !rail_full);

  p_loud_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hot)) |-> rail_full);

  p_min_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(rail_full) && $past(rail_mode == 2'b00)) |-> (run >= HOLD_TICKS + BASE_TICKS));
endmodule

bind classg_rail_ctrl classg_rail_ctrl_chk #(
  .SMP_W(SMP_W), .HOLD_TICKS(HOLD_TICKS), .BASE_TICKS(BASE_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_left(smp_left),
  .smp_right(smp_right), .level_thr(level_thr), .rail_mode(rail_mode),
  .quiet_code(quiet_code), .rail_full(rail_full)
);

// File: tb/classg_rail_ctrl_tb.sv
`timescale 1ns/1ps
module classg_rail_ctrl_tb;
  localparam int W    = 8;
  localparam int HOLD = 8;
  localparam int BASE = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                smp_stb = 1'b0;
  logic signed [W-1:0] smp_left = '0, smp_right = '0;
  logic        [W-1:0] level_thr = 8'd50;
  logic        [1:0]   rail_mode = 2'b00;
  logic        [2:0]   quiet_code = 3'd0;
  logic                rail_full;

  int checks = 0, errors = 0;
  int since = 0;
  bit exp_full = 1'b0, was_forced = 1'b0, exit_edge = 1'b0;

  always #2.5 clk = ~clk;

  classg_rail_ctrl #(.SMP_W(W), .HOLD_TICKS(HOLD), .BASE_TICKS(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_left(smp_left),
    .smp_right(smp_right), .level_thr(level_thr), .rail_mode(rail_mode),
    .quiet_code(quiet_code), .rail_full(rail_full)
  );

  function automatic int absv(input logic signed [W-1:0] s);
    int a = int'(s);
    return (a < 0) ? -a : a;
  endfunction

  function automatic bit is_loud();
    return smp_stb && (absv(smp_left) >= int'(level_thr) || absv(smp_right) >= int'(level_thr));
  endfunction

  task automatic model_edge();
    exit_edge = 1'b0;
    if (!rst_n) begin
      exp_full = 0; since = 0; was_forced = 0;
    end else if (rail_mode != 2'b00) begin
      exp_full = (rail_mode != 2'b10); since = 0; was_forced = 1;
    end else begin
      if (was_forced || is_loud()) begin
        exit_edge = was_forced;
        exp_full = 1; since = 0;
      end else if (exp_full) begin
        since++;
        if (since >= HOLD + (BASE << quiet_code)) exp_full = 0;
      end
      was_forced = 0;
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (rail_full !== exp_full) begin
      errors++;
      $display("FAIL %s: rail_full actual %0b expected %0b at %0t", tag, rail_full, exp_full, $time);
    end
  endtask

  function automatic string auto_tag();
    if (!rst_n) return "R1";
    if (rail_mode == 2'b10) return "R3";
    if (rail_mode != 2'b00) return "R2";
    if (exit_edge) return "R8";
    if (exp_full && since < HOLD) return "R6";
    return "R7";
  endfunction

  task automatic step(input string tag = "");
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag == "" ? auto_tag() : tag);
  endtask

  task automatic quiet_steps(input int n);
    smp_stb = 0; smp_left = 0; smp_right = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step("R1"); step("R1"); step("R1");
    rst_n = 1;
    quiet_steps(3);

    // R4: equality with threshold on left channel
    level_thr = 8'd50; smp_stb = 1; smp_left = 8'sd50; step("R4");
    // R6 and R7: exact fall cycle with code 0, then code 2
    quiet_steps(HOLD + BASE + 3);
    quiet_code = 3'd2;
    smp_stb = 1; smp_right = -8'sd60; step("R4");
    quiet_steps(4);
    smp_stb = 1; smp_left = 8'sd55; step("R6");
    quiet_steps(HOLD + (BASE << 2) + 3);
    // R4: just below threshold stays half
    smp_stb = 1; smp_left = 8'sd49; smp_right = -8'sd49; step("R4");
    // R5: loud values without strobe are ignored
    smp_stb = 0; smp_left = 8'sd127; smp_right = -8'sd128; step("R5"); step("R5");
    // R4: most negative code versus threshold 128
    level_thr = 8'd128; smp_stb = 1; smp_left = 8'sd0; smp_right = -8'sd128; step("R4");
    quiet_code = 3'd7;
    quiet_steps(HOLD + (BASE << 7) + 2);
    level_thr = 8'd50; quiet_code = 3'd0;
    // R2, R3, R8: forced modes and exit
    rail_mode = 2'b01; step("R2");
    rail_mode = 2'b11; step("R2");
    rail_mode = 2'b10; step("R3"); step("R3");
    rail_mode = 2'b00; step("R8");
    quiet_steps(HOLD + BASE + 2);
    // reset in the middle of full rail
    smp_stb = 1; smp_left = 8'sd100; step("R4");
    rst_n = 0; smp_stb = 0; step("R1");
    rst_n = 1; step("R1");

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        int r = $urandom_range(0, 9);
        rail_mode = (r < 7) ? 2'b00 : 2'($urandom_range(1, 3));
      end
      if ($urandom_range(0, 99) == 0) quiet_code = 3'($urandom_range(0, 3));
      if ($urandom_range(0, 299) == 0) level_thr = 8'($urandom_range(20, 128));
      smp_stb = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 39) == 0) begin
        smp_left = 8'($urandom); smp_right = 8'($urandom);
      end else begin
        smp_left = 8'(int'($urandom_range(0, 38)) - 19);
        smp_right = 8'(int'($urandom_range(0, 38)) - 19);
      end
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule